// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block holds the hazard logic of a five-stage in-order pipeline (fetch, decode/register read, execute, memory, writeback). It looks at register numbers, write enables and load flags of the instructions in flight. From these it produces the operand-source selects for the execute-stage ALU, and one stall decision that holds the PC, holds the fetch/decode register and turns the control bundle entering execute into a bubble. All of its logic is combinational. The datapath registers sit outside and use its outputs at the next clock edge.

Branches are resolved in decode. The block compares the two decode operands for equality and adds the branch offset to the decode PC. When the branch is taken it redirects the PC, so a taken branch costs one fetch slot. The decode comparison takes an ALU result from the execute/memory register when that register holds the value. If the value cannot be there in time, the branch waits. A mode pin picks between squashing the instruction fetched behind a taken branch and letting it run as a delay slot. The datapath, ALU and register file are outside this block. The register file is assumed to return the value being written in the same cycle it is read. There is no streaming data path, so every pin is a plain level signal.

Top module: `hazard_ctrl`

## Requirements
- R1: `fwd_a`/`fwd_b` encode the ALU operand source: 0 = register file value, 1 = execute/memory register, 2 = memory/writeback register. Code 1 is chosen when the memory-stage instruction writes (`mem_wen`), is not a load, and its destination equals the execute-stage source (`ex_rs` for `fwd_a`, `ex_rt` for `fwd_b`).
- R2: Code 2 is chosen when the writeback-stage instruction writes a destination equal to the execute-stage source and code 1 does not apply. This includes a loaded value.
- R3: When both the memory and writeback stages match the same source, the memory stage (code 1) wins.
- R4: Register 0 never counts as a dependency. A zero source or destination produces no forwarding and no stall.
- R5: A load in execute (`ex_load`, `ex_wen`) whose destination equals `id_rs` or `id_rt` raises `pc_hold`, `ifid_hold` and `idex_bubble` together in that cycle.
- R6: With no matching dependency, a non-branch in decode causes no stall. This covers a load whose destination differs, a writer with its write enable low, and a non-load ALU writer.
- R7: The decode branch operands are `id_rs_val`/`id_rt_val`, each replaced by `mem_alu` when the memory stage is a non-load writer of that register. A branch (`id_branch`) with equal operands and no stall raises `pc_redirect`, and `pc_target` = `id_pc` + `id_offset` modulo 2^XLEN.
- R8: A branch in decode stalls when any writer in execute targets one of its sources, or when a load in memory does.
- R9: A taken branch raises `ifid_flush` only when `delayed_mode` is 0. When `delayed_mode` is 1, the flush stays low.
- R10: While the stall is raised, `pc_redirect` and `ifid_flush` stay low.
- R11: Without `id_branch` there is no redirect and no flush. With all inputs at zero, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| delayed_mode | input | 1 | 1 = instruction after a branch always executes |
| id_rs | input | REG_AW | First source register of the decode instruction |
| id_rt | input | REG_AW | Second source register of the decode instruction |
| id_branch | input | 1 | Decode instruction is a branch-if-equal |
| id_rs_val | input | XLEN | Register file value for `id_rs` |
| id_rt_val | input | XLEN | Register file value for `id_rt` |
| id_pc | input | XLEN | Base PC for the branch target |
| id_offset | input | XLEN | Byte offset added to form the target |
| ex_rs | input | REG_AW | First source of the execute instruction |
| ex_rt | input | REG_AW | Second source of the execute instruction |
| ex_rd | input | REG_AW | Destination of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_alu | input | XLEN | ALU result held in the execute/memory register |
| wb_rd | input | REG_AW | Destination of the writeback instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Source select for ALU operand A |
| fwd_b | output | 2 | Source select for ALU operand B |
| pc_hold | output | 1 | Keep the PC unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Zero the control bundle entering execute |
| ifid_flush | output | 1 | Replace the fetch/decode register with a no-op |
| pc_redirect | output | 1 | Load `pc_target` into the PC |
| pc_target | output | XLEN | Taken-branch target address |

## Verification
The bench builds the block with REG_AW = 3 and XLEN = 16. It draws register numbers from 0 to 3 and operand values from 0 to 3. With so few registers and values, destination/source matches, register-0 cases, double matches that exercise the priority rule, and equal branch operands all occur in a large share of cycles. These draws reach every combination of load-use stall, branch stall, forwarding into the comparator and redirect under both branch modes. The 16-bit width also lets a directed target computation wrap around the address space.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } fwd_src_e;
  localparam int unsigned NUM_OPERANDS = 2;
endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output fwd_src_e          sel
);
  logic src_live, hit_mem, hit_wb;

  assign src_live = (src != '0);
  assign hit_mem  = src_live && mem_wen && !mem_load && (mem_rd == src);
  assign hit_wb   = src_live && wb_wen && (wb_rd == src);

  always_comb begin
    if (hit_mem)     sel = SRC_EXMEM;
    else if (hit_wb) sel = SRC_MEMWB;
    else             sel = SRC_RF;
  end
endmodule

// File: rtl/hzd_stall_detect.sv
module hzd_stall_detect #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_branch,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_load,
  output logic              load_stall,
  output logic              branch_stall
);
  logic ex_dep, mem_dep;

  assign ex_dep  = ex_wen && (ex_rd != '0) &&
                   ((ex_rd == id_rs) || (ex_rd == id_rt));
  assign mem_dep = mem_wen && (mem_rd != '0) &&
                   ((mem_rd == id_rs) || (mem_rd == id_rt));

  assign load_stall   = ex_dep && ex_load;
  assign branch_stall = id_branch && (ex_dep || (mem_dep && mem_load));
endmodule

// File: rtl/hzd_branch_unit.sv
module hzd_branch_unit
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned XLEN   = 32
) (
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic [XLEN-1:0]   id_rs_val,
  input  logic [XLEN-1:0]   id_rt_val,
  input  logic              id_branch,
  input  logic [XLEN-1:0]   id_pc,
  input  logic [XLEN-1:0]   id_offset,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_load,
  input  logic [XLEN-1:0]   mem_alu,
  input  logic              stall,
  input  logic              delayed_mode,
  output logic              redirect,
  output logic              flush,
  output logic [XLEN-1:0]   target
);
  logic [REG_AW-1:0] src   [NUM_OPERANDS];
  logic [XLEN-1:0]   rfval [NUM_OPERANDS];
  logic [XLEN-1:0]   opnd  [NUM_OPERANDS];
  logic              taken;

  assign src[0]   = id_rs;
  assign src[1]   = id_rt;
  assign rfval[0] = id_rs_val;
  assign rfval[1] = id_rt_val;

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_cmp_fwd
    logic use_mem;
    assign use_mem = mem_wen && !mem_load && (mem_rd != '0) && (mem_rd == src[g]);
    assign opnd[g] = use_mem ? mem_alu : rfval[g];
  end

  assign target   = id_pc + id_offset;
  assign taken    = id_branch && !stall && (opnd[0] == opnd[1]);
  assign redirect = taken;
  assign flush    = taken && !delayed_mode;
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned XLEN   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              delayed_mode,
  input  logic [REG_AW-1:0] id_rs,
  input  logic [REG_AW-1:0] id_rt,
  input  logic              id_branch,
  input  logic [XLEN-1:0]   id_rs_val,
  input  logic [XLEN-1:0]   id_rt_val,
  input  logic [XLEN-1:0]   id_pc,
  input  logic [XLEN-1:0]   id_offset,
  input  logic [REG_AW-1:0] ex_rs,
  input  logic [REG_AW-1:0] ex_rt,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              mem_load,
  input  logic [XLEN-1:0]   mem_alu,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_wen,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble,
  output logic              ifid_flush,
  output logic              pc_redirect,
  output logic [XLEN-1:0]   pc_target
);
  logic [REG_AW-1:0] ex_src [NUM_OPERANDS];
  fwd_src_e          sel    [NUM_OPERANDS];
  logic              load_stall, branch_stall, stall;

  assign ex_src[0] = ex_rs;
  assign ex_src[1] = ex_rt;

  // Operand source selection, one selector per ALU operand (R1, R2, R3)
  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_alu_fwd
    hzd_fwd_sel #(.REG_AW(REG_AW)) u_sel (
      .src      (ex_src[g]),
      .mem_rd   (mem_rd),
      .mem_wen  (mem_wen),
      .mem_load (mem_load),
      .wb_rd    (wb_rd),
      .wb_wen   (wb_wen),
      .sel      (sel[g])
    );
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  hzd_stall_detect #(.REG_AW(REG_AW)) u_stall (
    .id_rs        (id_rs),
    .id_rt        (id_rt),
    .id_branch    (id_branch),
    .ex_rd        (ex_rd),
    .ex_wen       (ex_wen),
    .ex_load      (ex_load),
    .mem_rd       (mem_rd),
    .mem_wen      (mem_wen),
    .mem_load     (mem_load),
    .load_stall   (load_stall),
    .branch_stall (branch_stall)
  );

  assign stall       = load_stall || branch_stall;
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_bubble = stall;

  hzd_branch_unit #(.REG_AW(REG_AW), .XLEN(XLEN)) u_branch (
    .id_rs        (id_rs),
    .id_rt        (id_rt),
    .id_rs_val    (id_rs_val),
    .id_rt_val    (id_rt_val),
    .id_branch    (id_branch),
    .id_pc        (id_pc),
    .id_offset    (id_offset),
    .mem_rd       (mem_rd),
    .mem_wen      (mem_wen),
    .mem_load     (mem_load),
    .mem_alu      (mem_alu),
    .stall        (stall),
    .delayed_mode (delayed_mode),
    .redirect     (pc_redirect),
    .flush        (ifid_flush),
    .target       (pc_target)
  );

  a_r1_exmem_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && !mem_load && mem_rd != '0 && mem_rd == ex_rs) |-> fwd_a == 2'd1);
  a_r3_exmem_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen && !mem_load && mem_rd != '0 && mem_rd == ex_rt &&
     wb_wen && wb_rd == ex_rt) |-> fwd_b == 2'd1);
  a_r4_zero_source: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs == '0) |-> fwd_a == 2'd0);
  a_r4_zero_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs == '0 && id_rt == '0) |-> !pc_hold);
  a_r5_load_use: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && ex_wen && ex_rd != '0 && (ex_rd == id_rs || ex_rd == id_rt))
      |-> (pc_hold && ifid_hold && idex_bubble));
  a_r9_delayed_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    delayed_mode |-> !ifid_flush);
  a_r10_stall_blocks_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> (!pc_redirect && !ifid_flush));
  a_r11_redirect_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
    pc_redirect |-> id_branch);
endmodule

// File: tb/tb_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_hazard_ctrl;
  localparam int AW = 3;
  localparam int XW = 16;

  logic clk = 1'b0, rst_n = 1'b0, delayed_mode;
  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic id_branch, ex_wen, ex_load, mem_wen, mem_load, wb_wen;
  logic [XW-1:0] id_rs_val, id_rt_val, id_pc, id_offset, mem_alu;
  logic [1:0] fwd_a, fwd_b;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush, pc_redirect;
  logic [XW-1:0] pc_target;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hazard_ctrl #(.REG_AW(AW), .XLEN(XW)) dut (
    .clk(clk), .rst_n(rst_n), .delayed_mode(delayed_mode),
    .id_rs(id_rs), .id_rt(id_rt), .id_branch(id_branch),
    .id_rs_val(id_rs_val), .id_rt_val(id_rt_val), .id_pc(id_pc), .id_offset(id_offset),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load), .mem_alu(mem_alu),
    .wb_rd(wb_rd), .wb_wen(wb_wen),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .idex_bubble(idex_bubble), .ifid_flush(ifid_flush),
    .pc_redirect(pc_redirect), .pc_target(pc_target)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int src_of(int s);
    // R1 R2 R3 R4: behavioural operand-source rule
    if (s != 0 && mem_wen && !mem_load && int'(mem_rd) == s) return 1;
    if (s != 0 && wb_wen && int'(wb_rd) == s) return 2;
    return 0;
  endfunction

  function automatic int cmp_val(int s, int rf);
    if (s != 0 && mem_wen && !mem_load && int'(mem_rd) == s) return int'(mem_alu);
    return rf;
  endfunction

  // Reference model evaluated every cycle
  task automatic compare();
    int rs = int'(id_rs), rt = int'(id_rt), xd = int'(ex_rd), md = int'(mem_rd);
    bit exdep, memdep, st, taken;
    logic [XW-1:0] tgt;
    exdep  = ex_wen && xd != 0 && (xd == rs || xd == rt);
    memdep = mem_wen && md != 0 && (md == rs || md == rt);
    st     = (exdep && ex_load) || (id_branch && (exdep || (memdep && mem_load))); // R5 R8
    taken  = id_branch && !st &&
             (cmp_val(rs, int'(id_rs_val)) == cmp_val(rt, int'(id_rt_val)));     // R7 R10
    tgt    = id_pc + id_offset;
    chk("R1", "fwd_a", int'(fwd_a), src_of(int'(ex_rs)));
    chk("R2", "fwd_b", int'(fwd_b), src_of(int'(ex_rt)));
    chk("R5", "pc_hold", int'(pc_hold), int'(st));
    chk("R5", "ifid_hold", int'(ifid_hold), int'(st));
    chk("R6", "idex_bubble", int'(idex_bubble), int'(st));
    chk("R7", "pc_redirect", int'(pc_redirect), int'(taken));
    chk("R9", "ifid_flush", int'(ifid_flush), int'(taken && !delayed_mode));
    if (taken) chk("R7", "pc_target", int'(pc_target), int'(tgt));
  endtask

  task automatic clr();
    delayed_mode = 0; id_rs = 0; id_rt = 0; id_branch = 0;
    id_rs_val = 0; id_rt_val = 0; id_pc = 0; id_offset = 0;
    ex_rs = 0; ex_rt = 0; ex_rd = 0; ex_wen = 0; ex_load = 0;
    mem_rd = 0; mem_wen = 0; mem_load = 0; mem_alu = 0; wb_rd = 0; wb_wen = 0;
  endtask

  task automatic step();
    @(negedge clk); #1 compare();
  endtask

  task automatic rnd();
    delayed_mode = 1'($urandom_range(0, 1));
    id_rs = AW'($urandom_range(0, 3)); id_rt = AW'($urandom_range(0, 3));
    id_branch = 1'($urandom_range(0, 1));
    id_rs_val = XW'($urandom_range(0, 3)); id_rt_val = XW'($urandom_range(0, 3));
    id_pc = XW'($urandom); id_offset = XW'($urandom);
    ex_rs = AW'($urandom_range(0, 3)); ex_rt = AW'($urandom_range(0, 3));
    ex_rd = AW'($urandom_range(0, 3));
    ex_wen = 1'($urandom_range(0, 1)); ex_load = 1'($urandom_range(0, 1));
    mem_rd = AW'($urandom_range(0, 3));
    mem_wen = 1'($urandom_range(0, 1)); mem_load = 1'($urandom_range(0, 1));
    mem_alu = XW'($urandom_range(0, 3));
    wb_rd = AW'($urandom_range(0, 3)); wb_wen = 1'($urandom_range(0, 1));
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    #1;
    // R11: idle outputs with all inputs zero
    chk("R11", "idle stall", int'(pc_hold | ifid_hold | idex_bubble), 0);
    chk("R11", "idle redirect", int'(pc_redirect | ifid_flush), 0);
    chk("R11", "idle fwd", int'(fwd_a) + int'(fwd_b), 0);
    rst_n = 1;
    // R1: memory-stage ALU result to operand A
    clr(); ex_rs = 2; mem_rd = 2; mem_wen = 1; step();
    chk("R1", "fwd_a exmem", int'(fwd_a), 1);
    // R2: writeback (load) to operand B
    clr(); ex_rt = 3; wb_rd = 3; wb_wen = 1; mem_rd = 3; mem_wen = 1; mem_load = 1; step();
    chk("R2", "fwd_b memwb", int'(fwd_b), 2);
    // R3: both match, memory stage wins
    clr(); ex_rs = 1; mem_rd = 1; mem_wen = 1; wb_rd = 1; wb_wen = 1; step();
    chk("R3", "fwd_a priority", int'(fwd_a), 1);
    // R4: register 0 never a dependency
    clr(); ex_rs = 0; mem_rd = 0; mem_wen = 1; id_rs = 0; ex_rd = 0; ex_wen = 1; ex_load = 1; step();
    chk("R4", "zero reg", int'(fwd_a) + int'(pc_hold), 0);
    // R5: load-use stall
    clr(); id_rt = 4; ex_rd = 4; ex_wen = 1; ex_load = 1; step();
    chk("R5", "load-use hold", int'(pc_hold & ifid_hold & idex_bubble), 1);
    // R6: load moved on to memory, non-branch consumer no longer stalls
    clr(); id_rt = 4; mem_rd = 4; mem_wen = 1; mem_load = 1; step();
    chk("R6", "no stall after load", int'(pc_hold), 0);
    // R8: branch waits for ALU result in execute
    clr(); id_branch = 1; id_rs = 5; ex_rd = 5; ex_wen = 1; step();
    chk("R8", "branch stall", int'(pc_hold), 1);
    chk("R10", "no redirect in stall", int'(pc_redirect | ifid_flush), 0);
    // R7: forwarded comparison, taken, target wraps modulo 2^16
    clr(); id_branch = 1; id_rs = 2; id_rt = 3; id_rs_val = 7; id_rt_val = 9;
    mem_rd = 2; mem_wen = 1; mem_alu = 9; id_pc = 16'hFFF0; id_offset = 16'h0020; step();
    chk("R7", "taken fwd", int'(pc_redirect), 1);
    chk("R7", "target wrap", int'(pc_target), 16'h0010);
    chk("R9", "flush normal mode", int'(ifid_flush), 1);
    delayed_mode = 1; step();
    chk("R9", "no flush delayed", int'(ifid_flush), 0);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); rnd(); #1 compare();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule